// File: doc/BRIEF.md
# Dual-Port RAM with Overlap Guard

A synchronous memory with two ports, A and B, sharing one clock. Each port has an enable, a write enable, an address, write data and a read-data register that updates on the clock edge. A configuration parameter selects true dual-port operation, where both ports read and write, or simple dual-port operation, where port A only writes and port B only reads. Each port has its own write mode. The mode sets what its read register shows on a cycle in which that port writes: the new data, the old contents, or its previous value unchanged.

A comparator watches a coarse upper slice of the two addresses. When both ports are enabled and the slices match, the ports are treated as overlapping. When an overlap happens and a read-first mode is in use, the collision policy decides what follows. Under the deferring policy, each overlapping write is parked in a one-entry holding register per port and lands in the array on the next edge. Forwarding hides the delay from every reader. Under the fast policy, the write is not protected and the target word becomes undefined. This policy is meant for systems that guarantee overlaps never occur.

A combinational flag reports two writes to the same full address in the same cycle. The stored word is undefined after such a cycle.

Top module: `dpram_guard`

## Requirements
- R1: With `PORT_CFG` set to simple dual-port, a write request on port B has no effect on the array, port B's read register loads on every enabled cycle, and `rdataA` keeps its reset value; true dual-port is the default.
- R2: On an enabled cycle without a write, a port's read register takes the word at its address on that edge; a disabled port keeps its read register unchanged.
- R3: In write-first mode, on a write cycle the port's read register takes that cycle's write data.
- R4: In read-first mode, on a write cycle the port's read register takes the word held at that address before the write.
- R5: In no-change mode, on a write cycle the port's read register keeps its previous value; the write still reaches the array.
- R6: A read on one port of a word that the other port writes in the same cycle returns the word's earlier contents.
- R7: Overlap means both ports are enabled and address bits `OVL_MSB` down to `OVL_LSB` are equal (bits 9 to 3 by default, so groups of 8 words). Protection applies only when read-first is in use: in simple dual-port mode, port A's mode is read-first; in true dual-port mode, either port's mode is read-first. Otherwise overlapping writes land normally under either policy.
- R8: Under the deferring policy (default), an overlapping write is committed one edge later. Any read of that full address in the meantime returns the deferred data.
- R9: A later non-deferred write to an address with a pending deferred write takes priority, and the address ends up holding the later data.
- R10: Under the fast policy, a protected overlapping write leaves the target word undefined instead of holding the written data.
- R11: `collide` is high, combinationally in the same cycle, exactly when both ports perform a write to the same full address; it stays low in simple dual-port mode.
- R12: While `rstN` is low, both read registers and the holding registers clear to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| addrA | input | ADDR_W | Port A word address |
| wdataA | input | DATA_W | Port A write data |
| rdataA | output | DATA_W | Port A registered read data |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable (ignored in simple dual-port) |
| addrB | input | ADDR_W | Port B word address |
| wdataB | input | DATA_W | Port B write data |
| rdataB | output | DATA_W | Port B registered read data |
| collide | output | 1 | Same-address double write in this cycle |

## Verification
The hardest situation to reach from the ports is a write still waiting in the holding register while the other port hits the same address on the following cycle. That case has two parts: a read that must be served by forwarding, and a write that must override the pending commit. The stimulus first creates an overlap by enabling both ports within one 8-word group. On the next cycle it drives the other port alone to the deferred address, once as a read and once as a write. It then reads the word back. The same stimulus drives a fast-policy instance and a non-read-first instance in parallel, so the corrupting case and the unprotected case are seen next to the protected one.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  localparam int NPORT = 2;

  typedef enum logic {
    CFG_TRUE_DUAL,
    CFG_SIMPLE_DUAL
  } port_cfg_e;

  typedef enum logic [1:0] {
    WM_WRITE_FIRST,
    WM_READ_FIRST,
    WM_NO_CHANGE
  } wmode_e;

  typedef enum logic {
    POL_DEFER,
    POL_FAST
  } policy_e;

  // Per-port strobes from control to datapath (bit 0 = port A, bit 1 = port B)
  typedef struct packed {
    logic [NPORT-1:0] wr;       // effective write
    logic [NPORT-1:0] defer;    // park write in holding register
    logic [NPORT-1:0] corrupt;  // store undefined word
    logic [NPORT-1:0] loadRd;   // update read register
    logic [NPORT-1:0] selWd;    // read register takes own write data
    logic             sameWord; // both ports write one full address
  } strobe_t;

endpackage

// File: rtl/dpg_ctrl.sv
module dpg_ctrl
  import dpg_pkg::*;
#(
  parameter port_cfg_e PORT_CFG = CFG_TRUE_DUAL,
  parameter wmode_e    WMODE_A  = WM_WRITE_FIRST,
  parameter wmode_e    WMODE_B  = WM_WRITE_FIRST,
  parameter policy_e   POLICY   = POL_DEFER,
  parameter int        ADDR_W   = 10,
  parameter int        OVL_MSB  = 9,
  parameter int        OVL_LSB  = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NPORT-1:0]             en,
  input  logic [NPORT-1:0]             we,
  input  logic [NPORT-1:0][ADDR_W-1:0] addr,
  output strobe_t                      strb
);

  localparam int SLICE_W = OVL_MSB - OVL_LSB + 1;
  localparam bit IS_SDP  = (PORT_CFG == CFG_SIMPLE_DUAL);
  localparam bit RF_USED = IS_SDP ? (WMODE_A == WM_READ_FIRST)
                                  : ((WMODE_A == WM_READ_FIRST) || (WMODE_B == WM_READ_FIRST));
  localparam bit DEFER   = (POLICY == POL_DEFER);

  logic [SLICE_W-1:0] sliceA, sliceB;
  logic               overlap, protect;
  logic [NPORT-1:0]   wrV, deferV, corruptV, loadV, selV;

  assign sliceA  = addr[0][OVL_MSB:OVL_LSB];
  assign sliceB  = addr[1][OVL_MSB:OVL_LSB];
  assign overlap = en[0] & en[1] & (sliceA == sliceB);
  assign protect = overlap & RF_USED;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam wmode_e MODE   = (p == 0) ? WMODE_A : WMODE_B;
    localparam bit     CAN_WR = !(IS_SDP && (p == 1));
    localparam bit     CAN_RD = !(IS_SDP && (p == 0));

    assign wrV[p]      = CAN_WR & en[p] & we[p];
    assign deferV[p]   = wrV[p] & protect & DEFER;
    assign corruptV[p] = wrV[p] & protect & !DEFER;
    assign loadV[p]    = CAN_RD & en[p] & ~(wrV[p] & (MODE == WM_NO_CHANGE));
    assign selV[p]     = wrV[p] & (MODE == WM_WRITE_FIRST);
  end

  always_comb begin
    strb.wr       = wrV;
    strb.defer    = deferV;
    strb.corrupt  = corruptV;
    strb.loadRd   = loadV;
    strb.selWd    = selV;
    strb.sameWord = wrV[0] & wrV[1] & (addr[0] == addr[1]);
  end

  // R7
  apart_no_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(en[0] && en[1] && (addr[0][OVL_MSB:OVL_LSB] == addr[1][OVL_MSB:OVL_LSB]))
      |-> (strb.defer == '0) && (strb.corrupt == '0));

endmodule

// File: rtl/dpg_datapath.sv
module dpg_datapath
  import dpg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [NPORT-1:0][ADDR_W-1:0] addr,
  input  logic [NPORT-1:0][DATA_W-1:0] wdata,
  output logic [NPORT-1:0][DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0]               mem [DEPTH];
  logic [NPORT-1:0]                pendV;
  logic [NPORT-1:0][ADDR_W-1:0]    pendAddr;
  logic [NPORT-1:0][DATA_W-1:0]    pendData;
  logic [NPORT-1:0][DATA_W-1:0]    fwd;

  // Array word, overridden by a pending deferred write to the same address
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      fwd[p] = mem[addr[p]];
      for (int q = 0; q < NPORT; q++) begin
        if (pendV[q] && (pendAddr[q] == addr[p])) fwd[p] = pendData[q];
      end
    end
  end

  // Pending commits first; fresh writes come later and win
  always_ff @(posedge clk) begin
    for (int q = 0; q < NPORT; q++) begin
      if (pendV[q]) mem[pendAddr[q]] <= pendData[q];
    end
    for (int p = 0; p < NPORT; p++) begin
      if (strb.wr[p] && !strb.defer[p])
        mem[addr[p]] <= strb.corrupt[p] ? {DATA_W{1'bx}} : wdata[p];
    end
    if (strb.sameWord) mem[addr[0]] <= {DATA_W{1'bx}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendV    <= '0;
      pendAddr <= '0;
      pendData <= '0;
      rdata    <= '0;
    end else begin
      pendV <= strb.defer;
      for (int p = 0; p < NPORT; p++) begin
        if (strb.defer[p]) begin
          pendAddr[p] <= addr[p];
          pendData[p] <= wdata[p];
        end
        if (strb.loadRd[p]) rdata[p] <= strb.selWd[p] ? wdata[p] : fwd[p];
      end
    end
  end

  // R2
  hold_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadRd[0] |=> $stable(rdata[0]));

  // R2
  hold_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadRd[1] |=> $stable(rdata[1]));

  // R8
  park_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.defer[0] |=> pendV[0] && (pendData[0] == $past(wdata[0])));

  // R8
  park_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.defer[1] |=> pendV[1] && (pendAddr[1] == $past(addr[1])));

endmodule

// File: rtl/dpram_guard.sv
module dpram_guard
  import dpg_pkg::*;
#(
  parameter port_cfg_e PORT_CFG = CFG_TRUE_DUAL,
  parameter wmode_e    WMODE_A  = WM_WRITE_FIRST,
  parameter wmode_e    WMODE_B  = WM_WRITE_FIRST,
  parameter policy_e   POLICY   = POL_DEFER,
  parameter int        ADDR_W   = 10,
  parameter int        DATA_W   = 16,
  parameter int        OVL_MSB  = 9,
  parameter int        OVL_LSB  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enA,
  input  logic              weA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] wdataA,
  output logic [DATA_W-1:0] rdataA,
  input  logic              enB,
  input  logic              weB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] wdataB,
  output logic [DATA_W-1:0] rdataB,
  output logic              collide
);

  strobe_t                      strb;
  logic [NPORT-1:0][ADDR_W-1:0] addrV;
  logic [NPORT-1:0][DATA_W-1:0] wdataV;
  logic [NPORT-1:0][DATA_W-1:0] rdataV;

  assign addrV  = {addrB, addrA};
  assign wdataV = {wdataB, wdataA};
  assign rdataA = rdataV[0];
  assign rdataB = rdataV[1];
  assign collide = strb.sameWord;

  dpg_ctrl #(
    .PORT_CFG(PORT_CFG), .WMODE_A(WMODE_A), .WMODE_B(WMODE_B), .POLICY(POLICY),
    .ADDR_W(ADDR_W), .OVL_MSB(OVL_MSB), .OVL_LSB(OVL_LSB)
  ) i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .en   ({enB, enA}),
    .we   ({weB, weA}),
    .addr (addrV),
    .strb (strb)
  );

  dpg_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .addr  (addrV),
    .wdata (wdataV),
    .rdata (rdataV)
  );

  // R5
  nochg_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (PORT_CFG == CFG_TRUE_DUAL) && (WMODE_A == WM_NO_CHANGE) && enA && weA |=> $stable(rdataA));

  // R5
  nochg_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (PORT_CFG == CFG_TRUE_DUAL) && (WMODE_B == WM_NO_CHANGE) && enB && weB |=> $stable(rdataB));

  // R3
  wfirst_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (PORT_CFG == CFG_TRUE_DUAL) && (WMODE_A == WM_WRITE_FIRST) && enA && weA
      |=> rdataA == $past(wdataA));

  // R1
  sdp_a_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (PORT_CFG == CFG_SIMPLE_DUAL) && enA |=> $stable(rdataA));

  // R11
  sdp_no_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (PORT_CFG == CFG_SIMPLE_DUAL) |-> !collide);

endmodule

// File: tb/test_dpram_guard.sv
`timescale 1ns/1ps
module test_dpram_guard;
  import dpg_pkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enA, weA, enB, weB;
  logic [9:0]  addrA, addrB;
  logic [15:0] wdA, wdB;
  logic [15:0] rdA [4];
  logic [15:0] rdB [4];
  logic        col [4];
  logic        colSnap [4];
  int          errs = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  // 0: TDP WF/RF defer   1: TDP NC/WF fast (no read-first)
  // 2: TDP RF/RF fast    3: SDP RF defer
  dpram_guard #(.WMODE_A(WM_WRITE_FIRST), .WMODE_B(WM_READ_FIRST)) i_dpram_guard (
    .clk(clk), .rstN(rstN), .enA(enA), .weA(weA), .addrA(addrA), .wdataA(wdA), .rdataA(rdA[0]),
    .enB(enB), .weB(weB), .addrB(addrB), .wdataB(wdB), .rdataB(rdB[0]), .collide(col[0]));

  dpram_guard #(.WMODE_A(WM_NO_CHANGE), .WMODE_B(WM_WRITE_FIRST), .POLICY(POL_FAST)) i_dpram_guard_nc (
    .clk(clk), .rstN(rstN), .enA(enA), .weA(weA), .addrA(addrA), .wdataA(wdA), .rdataA(rdA[1]),
    .enB(enB), .weB(weB), .addrB(addrB), .wdataB(wdB), .rdataB(rdB[1]), .collide(col[1]));

  dpram_guard #(.WMODE_A(WM_READ_FIRST), .WMODE_B(WM_READ_FIRST), .POLICY(POL_FAST)) i_dpram_guard_fast (
    .clk(clk), .rstN(rstN), .enA(enA), .weA(weA), .addrA(addrA), .wdataA(wdA), .rdataA(rdA[2]),
    .enB(enB), .weB(weB), .addrB(addrB), .wdataB(wdB), .rdataB(rdB[2]), .collide(col[2]));

  dpram_guard #(.PORT_CFG(CFG_SIMPLE_DUAL), .WMODE_A(WM_READ_FIRST)) i_dpram_guard_sdp (
    .clk(clk), .rstN(rstN), .enA(enA), .weA(weA), .addrA(addrA), .wdataA(wdA), .rdataA(rdA[3]),
    .enB(enB), .weB(weB), .addrB(addrB), .wdataB(wdB), .rdataB(rdB[3]), .collide(col[3]));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle, snapshot collide before the edge, return just after the edge
  task automatic cyc(input logic ea, input logic wa, input logic [9:0] aa, input logic [15:0] da,
                     input logic eb, input logic wb, input logic [9:0] ab, input logic [15:0] db);
    enA = ea; weA = wa; addrA = aa; wdA = da;
    enB = eb; weB = wb; addrB = ab; wdB = db;
    #1;
    for (int i = 0; i < 4; i++) colSnap[i] = col[i];
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 10'h0, 16'h0, 1'b0, 1'b0, 10'h0, 16'h0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      chk(rdA[i] == 16'h0, "R12 rdataA after reset", rdA[i], 16'h0);
      chk(rdB[i] == 16'h0, "R12 rdataB after reset", rdB[i], 16'h0);
    end
  endtask

  task automatic t_basic();
    cyc(1'b1, 1'b1, 10'h010, 16'h1111, 1'b0, 1'b0, 10'h0, 16'h0);
    chk(rdA[0] == 16'h1111, "R3 write-first echo", rdA[0], 16'h1111);
    chk(rdA[1] == 16'h0000, "R5 no-change holds", rdA[1], 16'h0000);
    chk(rdA[3] == 16'h0000, "R1 sdp port A read quiet", rdA[3], 16'h0000);
    cyc(1'b0, 1'b0, 10'h0, 16'h0, 1'b1, 1'b0, 10'h010, 16'h0);
    chk(rdB[0] == 16'h1111, "R2 read returns word", rdB[0], 16'h1111);
    chk(rdA[0] == 16'h1111, "R2 disabled port holds", rdA[0], 16'h1111);
    chk(rdB[2] == 16'h1111, "R2 read fast instance", rdB[2], 16'h1111);
    chk(rdB[3] == 16'h1111, "R1 sdp port B reads", rdB[3], 16'h1111);
  endtask

  task automatic t_readfirst();
    cyc(1'b0, 1'b0, 10'h0, 16'h0, 1'b1, 1'b1, 10'h010, 16'h2222);
    chk(rdB[0] == 16'h1111, "R4 read-first old data", rdB[0], 16'h1111);
    chk(rdB[1] == 16'h2222, "R3 write-first port B", rdB[1], 16'h2222);
    chk(rdB[3] == 16'h1111, "R1 sdp B loads while weB set", rdB[3], 16'h1111);
    cyc(1'b1, 1'b0, 10'h010, 16'h0, 1'b0, 1'b0, 10'h0, 16'h0);
    chk(rdA[0] == 16'h2222, "R4 write landed", rdA[0], 16'h2222);
    chk(rdA[1] == 16'h2222, "R5 no-change loads on read", rdA[1], 16'h2222);
    chk(rdA[3] == 16'h0000, "R1 sdp port A never reads", rdA[3], 16'h0000);
    cyc(1'b0, 1'b0, 10'h0, 16'h0, 1'b1, 1'b0, 10'h010, 16'h0);
    chk(rdB[3] == 16'h1111, "R1 sdp port B write ignored", rdB[3], 16'h1111);
  endtask

  task automatic t_nochange();
    cyc(1'b1, 1'b1, 10'h018, 16'h3333, 1'b0, 1'b0, 10'h0, 16'h0);
    chk(rdA[1] == 16'h2222, "R5 no-change keeps value", rdA[1], 16'h2222);
    cyc(1'b1, 1'b0, 10'h018, 16'h0, 1'b0, 1'b0, 10'h0, 16'h0);
    chk(rdA[1] == 16'h3333, "R5 no-change write stored", rdA[1], 16'h3333);
  endtask

  task automatic t_defer();
    cyc(1'b1, 1'b1, 10'h020, 16'h5555, 1'b0, 1'b0, 10'h0, 16'h0);
    // overlap: A writes, B reads the same word
    cyc(1'b1, 1'b1, 10'h020, 16'hAAAA, 1'b1, 1'b0, 10'h020, 16'h0);
    chk(rdB[0] == 16'h5555, "R6 cross-port read old", rdB[0], 16'h5555);
    chk(rdA[0] == 16'hAAAA, "R3 write-first under overlap", rdA[0], 16'hAAAA);
    chk(rdB[3] == 16'h5555, "R6 sdp cross-port read old", rdB[3], 16'h5555);
    cyc(1'b0, 1'b0, 10'h0, 16'h0, 1'b1, 1'b0, 10'h020, 16'h0);
    chk(rdB[0] == 16'hAAAA, "R8 pending data forwarded", rdB[0], 16'hAAAA);
    chk(rdB[3] == 16'hAAAA, "R8 sdp pending forwarded", rdB[3], 16'hAAAA);
    cyc(1'b1, 1'b1, 10'h020, 16'hBBBB, 1'b1, 1'b0, 10'h020, 16'h0);
    chk(rdB[0] == 16'hAAAA, "R8 deferred write committed", rdB[0], 16'hAAAA);
    cyc(1'b0, 1'b0, 10'h0, 16'h0, 1'b1, 1'b1, 10'h020, 16'hCCCC);
    chk(rdB[0] == 16'hBBBB, "R8 read-first sees pending", rdB[0], 16'hBBBB);
    chk(rdB[3] == 16'hBBBB, "R1 sdp B reads pending", rdB[3], 16'hBBBB);
    cyc(1'b1, 1'b0, 10'h020, 16'h0, 1'b0, 1'b0, 10'h0, 16'h0);
    chk(rdA[0] == 16'hCCCC, "R9 later write wins", rdA[0], 16'hCCCC);
    chk(rdA[1] == 16'hCCCC, "R9 unprotected instance", rdA[1], 16'hCCCC);
    chk(rdA[3] == 16'h0000, "R1 sdp rdataA stays reset", rdA[3], 16'h0000);
    cyc(1'b0, 1'b0, 10'h0, 16'h0, 1'b1, 1'b0, 10'h020, 16'h0);
    chk(rdB[3] == 16'hBBBB, "R1 sdp B write had no effect", rdB[3], 16'hBBBB);
  endtask

  task automatic t_fast();
    cyc(1'b1, 1'b1, 10'h040, 16'h7777, 1'b0, 1'b0, 10'h0, 16'h0);
    // overlap on group 8: A writes 0x040, B reads 0x041
    cyc(1'b1, 1'b1, 10'h040, 16'h9999, 1'b1, 1'b0, 10'h041, 16'h0);
    chk(rdA[2] == 16'h7777, "R4 read-first under overlap", rdA[2], 16'h7777);
    cyc(1'b0, 1'b0, 10'h0, 16'h0, 1'b1, 1'b0, 10'h040, 16'h0);
    chk(rdB[0] == 16'h9999, "R8 deferring policy keeps data", rdB[0], 16'h9999);
    chk(rdB[2] !== 16'h9999, "R10 fast policy corrupts (expected differs)", rdB[2], 16'h9999);
    chk(rdB[1] == 16'h9999, "R7 no read-first no guard", rdB[1], 16'h9999);
    // different groups: 0x048 vs 0x040, no overlap on fast instance
    cyc(1'b1, 1'b1, 10'h048, 16'h4242, 1'b1, 1'b0, 10'h040, 16'h0);
    cyc(1'b0, 1'b0, 10'h0, 16'h0, 1'b1, 1'b0, 10'h048, 16'h0);
    chk(rdB[2] == 16'h4242, "R7 separate groups unaffected", rdB[2], 16'h4242);
  endtask

  task automatic t_collide();
    cyc(1'b1, 1'b1, 10'h050, 16'h0001, 1'b1, 1'b1, 10'h050, 16'h0002);
    chk(colSnap[0] == 1'b1, "R11 same-address double write", {15'h0, colSnap[0]}, 16'h1);
    chk(colSnap[3] == 1'b0, "R11 sdp never collides", {15'h0, colSnap[3]}, 16'h0);
    cyc(1'b1, 1'b1, 10'h050, 16'h0001, 1'b1, 1'b1, 10'h051, 16'h0002);
    chk(colSnap[0] == 1'b0, "R11 distinct addresses", {15'h0, colSnap[0]}, 16'h0);
    cyc(1'b1, 1'b1, 10'h060, 16'h0001, 1'b1, 1'b0, 10'h060, 16'h0);
    chk(colSnap[0] == 1'b0, "R11 write plus read", {15'h0, colSnap[0]}, 16'h0);
  endtask

  initial begin
    rstN = 1'b0;
    enA = 1'b0; weA = 1'b0; addrA = '0; wdA = '0;
    enB = 1'b0; weB = 1'b0; addrB = '0; wdB = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    idle();
    t_basic();
    t_readfirst();
    t_nochange();
    t_defer();
    t_fast();
    t_collide();
    idle();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      checks++;
      $display("FAIL watchdog R1-run: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule